// File: doc/BRIEF.md
# Trigger-Buffered Event Capture Manager

The block takes a front-end sample stream and, for every trigger it accepts, stores one fixed-length event in a circular buffer shared by several events. Each stored event opens with a header word that holds a marker and the trigger's sequence number. The sample words follow the header. When the last sample word of an event has been written, the block pushes one descriptor into a small FIFO. The descriptor carries the event's start address, its length in words and its trigger number.

A downstream packet builder works on its own schedule. It pops a descriptor, fetches the event's words through a synchronous read port, and pulses a release strobe when it has finished with the event. Capture and readout therefore overlap. BUSY tells the trigger source when no further trigger can be taken: while an event is being captured, and whenever the buffer has no room for one more complete event. A legacy mode can be selected in which BUSY stays high from the trigger until that event has been released, so that at most one event is outstanding.

With the default parameters an event has 4 channels × 3 time samples + 1 header = 13 words, and the buffer holds 10 events (130 words).

Top module: `evt_capture_mgr`

## Requirements
- R1: After reset, `busy` is 0, `desc_valid` is 0 and `rej_count` is 0.
- R2: An accepted trigger (`trig_in` high while `busy` is low) writes a header word at the event's start address. Bits 31:24 of the header hold the marker 0xE7. Bits 23:0 hold the trigger number, which is 0 for the first accepted trigger after reset and rises by one on each accepted trigger.
- R3: During a capture, each cycle with `smp_valid` high stores `smp_data` at the next buffer address after the header, wrapping modulo the buffer depth. `smp_valid` has no effect outside a capture.
- R4: `busy` is high from the cycle after an accepted trigger until the edge that stores the event's last sample word.
- R5: At the edge that stores the last sample word, one descriptor is pushed. It holds the start address, the length 13 and the trigger number. Descriptors leave the FIFO in capture order, one per `desc_pop` pulse while `desc_valid` is high.
- R6: In buffered mode, `busy` falls as soon as capture ends while room remains, without any pop or release.
- R7: `busy` is high whenever fewer than 13 buffer words are unreserved. With the defaults this means 10 pending events. It falls the cycle after one of those events is released.
- R8: A release pulse frees the 13 words of the oldest event and advances the buffer's read base by 13 modulo the depth. A release pulse is ignored when no event has been popped and not yet released.
- R9: With `unbuf_mode` = 1, `busy` stays high from an accepted trigger until that event has been released.
- R10: A trigger seen while `busy` is high stores nothing and adds one to `rej_count`, which saturates at 0xFFFF.
- R11: A trigger accepted in the same cycle as a release both take effect: the new event reserves its words and the released event's words are freed.
- R12: `rd_data` shows the word at `rd_addr` one clock after that address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unbuf_mode | input | 1 | 1 selects legacy single-event operation; change only while idle |
| trig_in | input | 1 | Trigger request, one cycle per trigger |
| smp_valid | input | 1 | Sample word valid |
| smp_data | input | 32 | Sample word |
| desc_valid | output | 1 | A descriptor is available |
| desc_pop | input | 1 | Take the current descriptor |
| desc_addr | output | 8 | Event start address |
| desc_len | output | 4 | Event length in words, header included |
| desc_trig | output | 24 | Event trigger number |
| rd_addr | input | 8 | Buffer read address |
| rd_data | output | 32 | Buffer word, one-cycle latency |
| evt_release | input | 1 | Oldest popped event is no longer needed |
| busy | output | 1 | No trigger can be accepted |
| rej_count | output | 16 | Saturating count of rejected triggers |

## Verification
The interesting collision is a new trigger being accepted in the same cycle as a release. The first reserves a whole event's words and the second returns a whole event's words, both in the same occupancy update. The bench builds up nine pending events, pops one, and then drives the trigger and the release on the same edge. If both updates land, `busy` falls once that capture ends, and it rises only after one further event has been captured. If either update is lost, BUSY shows the error one event early or one event late. A second collision, a release pulse with no event popped, is checked with a full buffer: `busy` must stay high through that pulse.

// File: rtl/evt_cap_pkg.sv
package evt_cap_pkg;
  typedef enum logic [0:0] {
    CAP_IDLE = 1'b0,
    CAP_RUN  = 1'b1
  } cap_state_e;
endpackage

// File: rtl/evt_ring_mem.sv
// Event storage: one write port, one registered read port.
module evt_ring_mem #(
  parameter int W     = 32,
  parameter int DEPTH = 130,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= store_q[raddr];
  end
endmodule

// File: rtl/evt_desc_fifo.sv
// Descriptor queue, one entry per completed event.
module evt_desc_fifo #(
  parameter int W     = 36,
  parameter int DEPTH = 10,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         valid,
  output logic         full
);
  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign valid  = (cnt_q != '0);
  assign full   = (cnt_q == CW'(DEPTH));
  assign do_pop = pop & valid;
  assign dout   = slot_q[head_q];

  always_comb begin
    head_d = do_pop ? nxt(head_q) : head_q;
    tail_d = push ? nxt(tail_q) : tail_q;
    cnt_d  = cnt_q;
    if (push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot_q[tail_q] <= din;
  end

  AST_DESC_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R5
endmodule

// File: rtl/evt_space_track.sv
// Word occupancy of the ring and its read base.
module evt_space_track #(
  parameter int EVT_WORDS = 13,
  parameter int DEPTH     = 130,
  parameter int AW        = 8,
  parameter int UW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reserve,
  input  logic          free,
  output logic [UW-1:0] used,
  output logic [AW-1:0] rd_base,
  output logic          space_low
);
  logic [UW-1:0] used_d;
  logic [AW-1:0] base_d;
  logic [AW:0]   base_sum;

  assign space_low = (used > UW'(DEPTH - EVT_WORDS));
  assign base_sum  = {1'b0, rd_base} + (AW+1)'(EVT_WORDS);

  always_comb begin
    used_d = used;
    if (reserve && !free)      used_d = used + UW'(EVT_WORDS);
    else if (free && !reserve) used_d = used - UW'(EVT_WORDS);
    base_d = rd_base;
    if (free) base_d = (base_sum >= (AW+1)'(DEPTH)) ? AW'(base_sum - (AW+1)'(DEPTH))
                                                    : AW'(base_sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used    <= '0;
      rd_base <= '0;
    end else begin
      used    <= used_d;
      rd_base <= base_d;
    end
  end

  AST_NO_BUF_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) used <= UW'(DEPTH)); // R7
  AST_FREE_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n) (free && !reserve) |-> used >= UW'(EVT_WORDS)); // R8
endmodule

// File: rtl/evt_capture_mgr.sv
module evt_capture_mgr
  import evt_cap_pkg::*;
#(
  parameter int          DATA_W       = 32,
  parameter int          CHANNELS     = 4,
  parameter int          TIME_SAMPLES = 3,
  parameter int          MAX_EVENTS   = 10,
  parameter logic [7:0]  MARKER       = 8'hE7,
  parameter int          REJ_W        = 16,
  localparam int SAMP_WORDS = CHANNELS * TIME_SAMPLES,
  localparam int EVT_WORDS  = SAMP_WORDS + 1,
  localparam int BUF_DEPTH  = MAX_EVENTS * EVT_WORDS,
  localparam int AW         = $clog2(BUF_DEPTH),
  localparam int LW         = $clog2(EVT_WORDS + 1),
  localparam int TRIG_W     = DATA_W - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unbuf_mode,
  input  logic              trig_in,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              desc_valid,
  input  logic              desc_pop,
  output logic [AW-1:0]     desc_addr,
  output logic [LW-1:0]     desc_len,
  output logic [TRIG_W-1:0] desc_trig,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              evt_release,
  output logic              busy,
  output logic [REJ_W-1:0]  rej_count
);
  localparam int SCW    = $clog2(SAMP_WORDS + 1);
  localparam int UW     = $clog2(BUF_DEPTH + 1);
  localparam int HW     = $clog2(MAX_EVENTS + 1);
  localparam int DESC_W = AW + LW + TRIG_W;

  cap_state_e        state_q, state_d;
  logic [AW-1:0]     wr_ptr_q, wr_ptr_d, start_q, start_d;
  logic [SCW-1:0]    scnt_q, scnt_d;
  logic [TRIG_W-1:0] tcnt_q, tcnt_d, cur_trig_q, cur_trig_d;
  logic [HW-1:0]     held_q, held_d;
  logic [REJ_W-1:0]  rej_q, rej_d;

  logic              acc_trig, pop_ok, rel_ok, push;
  logic              wr_en, space_low, fifo_full;
  logic [AW-1:0]     rd_base;
  logic [UW-1:0]     used;
  logic [DATA_W-1:0] wr_data;
  logic [DESC_W-1:0] desc_in, desc_out;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(BUF_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign busy      = (state_q == CAP_RUN) | space_low | (unbuf_mode & (used != '0));
  assign acc_trig  = trig_in & ~busy;
  assign pop_ok    = desc_pop & desc_valid;
  assign rel_ok    = evt_release & (held_q != '0);
  assign rej_count = rej_q;

  // Capture sequencing, counters and release bookkeeping
  always_comb begin
    state_d    = state_q;
    wr_ptr_d   = wr_ptr_q;
    start_d    = start_q;
    scnt_d     = scnt_q;
    tcnt_d     = tcnt_q;
    cur_trig_d = cur_trig_q;
    wr_en      = 1'b0;
    wr_data    = smp_data;
    push       = 1'b0;
    unique case (state_q)
      CAP_IDLE: begin
        if (acc_trig) begin
          wr_en      = 1'b1;
          wr_data    = {MARKER, tcnt_q};
          start_d    = wr_ptr_q;
          wr_ptr_d   = ptr_inc(wr_ptr_q);
          cur_trig_d = tcnt_q;
          tcnt_d     = tcnt_q + 1'b1;
          scnt_d     = '0;
          state_d    = CAP_RUN;
        end
      end
      CAP_RUN: begin
        if (smp_valid) begin
          wr_en    = 1'b1;
          wr_ptr_d = ptr_inc(wr_ptr_q);
          scnt_d   = scnt_q + 1'b1;
          if (scnt_q == SCW'(SAMP_WORDS - 1)) begin
            push    = 1'b1;
            state_d = CAP_IDLE;
          end
        end
      end
      default: state_d = CAP_IDLE;
    endcase

    rej_d = rej_q;
    if (trig_in && busy && (rej_q != {REJ_W{1'b1}})) rej_d = rej_q + 1'b1;

    held_d = held_q;
    if (pop_ok && !rel_ok)      held_d = held_q + 1'b1;
    else if (rel_ok && !pop_ok) held_d = held_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= CAP_IDLE;
      wr_ptr_q   <= '0;
      start_q    <= '0;
      scnt_q     <= '0;
      tcnt_q     <= '0;
      cur_trig_q <= '0;
      held_q     <= '0;
      rej_q      <= '0;
    end else begin
      state_q    <= state_d;
      wr_ptr_q   <= wr_ptr_d;
      start_q    <= start_d;
      scnt_q     <= scnt_d;
      tcnt_q     <= tcnt_d;
      cur_trig_q <= cur_trig_d;
      held_q     <= held_d;
      rej_q      <= rej_d;
    end
  end

  evt_ring_mem #(.W(DATA_W), .DEPTH(BUF_DEPTH), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_ptr_q),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  evt_space_track #(.EVT_WORDS(EVT_WORDS), .DEPTH(BUF_DEPTH), .AW(AW), .UW(UW)) u_space (
    .clk       (clk),
    .rst_n     (rst_n),
    .reserve   (acc_trig),
    .free      (rel_ok),
    .used      (used),
    .rd_base   (rd_base),
    .space_low (space_low)
  );

  assign desc_in = {start_q, LW'(EVT_WORDS), cur_trig_q};

  evt_desc_fifo #(.W(DESC_W), .DEPTH(MAX_EVENTS)) u_desc (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   (desc_in),
    .pop   (desc_pop),
    .dout  (desc_out),
    .valid (desc_valid),
    .full  (fifo_full)
  );

  assign desc_addr = desc_out[DESC_W-1 -: AW];
  assign desc_len  = desc_out[TRIG_W +: LW];
  assign desc_trig = desc_out[TRIG_W-1:0];

  // Read base plus reserved words must meet the write pointer between events
  logic [UW:0] base_plus_used;
  logic [AW-1:0] exp_wr;
  assign base_plus_used = (UW+1)'(rd_base) + (UW+1)'(used);
  assign exp_wr = (base_plus_used >= (UW+1)'(BUF_DEPTH)) ? AW'(base_plus_used - (UW+1)'(BUF_DEPTH))
                                                        : AW'(base_plus_used);

  AST_CAPTURE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) acc_trig |=> busy); // R4
  AST_UNBUF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) (unbuf_mode && desc_valid) |-> busy); // R9
  AST_REJ_SATURATE: assert property (@(posedge clk) disable iff (!rst_n) (rej_q == {REJ_W{1'b1}}) |=> (rej_q == {REJ_W{1'b1}})); // R10
  AST_PTR_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n) (state_q == CAP_IDLE) |-> (exp_wr == wr_ptr_q)); // R8
  AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n) push |-> !fifo_full); // R5
endmodule

// File: tb/evt_capture_mgr_test.sv
module evt_capture_mgr_test;
  localparam int CLK_P = 10;
  localparam int EVT   = 13;
  localparam int NSAMP = 12;
  localparam int DEPTH = 130;

  logic        clk = 1'b0;
  logic        rst_n, unbuf_mode, trig_in, smp_valid, desc_pop, evt_release;
  logic [31:0] smp_data, rd_data;
  logic        desc_valid, busy;
  logic [7:0]  desc_addr, rd_addr;
  logic [3:0]  desc_len;
  logic [23:0] desc_trig;
  logic [15:0] rej_count;

  int n_tests = 0, n_fail = 0;
  int exp_trig = 0, exp_wr = 0, exp_rej = 0;
  int qa [64];
  int qt [64];
  int qh = 0, qtl = 0;

  always #(CLK_P/2) clk = ~clk;

  evt_capture_mgr uut (
    .clk(clk), .rst_n(rst_n), .unbuf_mode(unbuf_mode), .trig_in(trig_in),
    .smp_valid(smp_valid), .smp_data(smp_data), .desc_valid(desc_valid),
    .desc_pop(desc_pop), .desc_addr(desc_addr), .desc_len(desc_len),
    .desc_trig(desc_trig), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_release(evt_release), .busy(busy), .rej_count(rej_count)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic read_word(input int addr, output logic [31:0] val);
    rd_addr = 8'(addr);
    @(negedge clk);
    val = rd_data;
  endtask

  // Capture one event; extra = trigger cycles held after acceptance
  task automatic capture(input logic [31:0] base, input bit gaps, input int extra);
    chk("R6 idle before trigger", busy, 1'b0);
    trig_in = 1'b1;
    @(negedge clk);
    for (int k = 0; k < extra; k++) @(negedge clk);
    trig_in = 1'b0;
    chk("R4 busy in capture", busy, 1'b1);
    qa[qtl % 64] = exp_wr;
    qt[qtl % 64] = exp_trig;
    qtl++;
    exp_wr  = (exp_wr + EVT) % DEPTH;
    exp_trig++;
    exp_rej += extra;
    for (int i = 0; i < NSAMP; i++) begin
      smp_valid = 1'b1;
      smp_data  = base + 32'(i);
      @(negedge clk);
      smp_valid = 1'b0;
      if (gaps && i < NSAMP - 1) begin
        @(negedge clk);
        chk("R4 busy across gap", busy, 1'b1);
      end
    end
  endtask

  task automatic pop_one();
    chk("R5 desc valid", desc_valid, 1'b1);
    chk("R5 desc addr", desc_addr, 32'(qa[qh % 64]));
    chk("R5 desc trig", desc_trig, 32'(qt[qh % 64]));
    chk("R5 desc len", desc_len, 32'(EVT));
    desc_pop = 1'b1;
    @(negedge clk);
    desc_pop = 1'b0;
    qh++;
  endtask

  task automatic release_one();
    evt_release = 1'b1;
    @(negedge clk);
    evt_release = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; unbuf_mode = 1'b0; trig_in = 1'b0; smp_valid = 1'b0;
    smp_data = '0; desc_pop = 1'b0; evt_release = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 1'b0);
    chk("R1 desc_valid", desc_valid, 1'b0);
    chk("R1 rej_count", rej_count, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_single();
    logic [31:0] v;
    int a;
    capture(32'h1000, 1'b1, 0);
    chk("R6 ready without readout", busy, 1'b0);
    chk("R5 push after last word", desc_valid, 1'b1);
    a = qa[qh % 64];
    read_word(a, v);
    chk("R2 header first event", v, {8'hE7, 24'd0});
    for (int i = 0; i < NSAMP; i++) begin
      read_word((a + 1 + i) % DEPTH, v);
      chk("R3 R12 sample word", v, 32'h1000 + 32'(i));
    end
    // samples outside capture must be dropped
    smp_valid = 1'b1; smp_data = 32'hDEAD_BEEF;
    repeat (2) @(negedge clk);
    smp_valid = 1'b0;
    capture(32'h2000, 1'b0, 0);
    a = qa[(qh + 1) % 64];
    read_word(a, v);
    chk("R2 header increments", v, {8'hE7, 24'd1});
    read_word((a + 1) % DEPTH, v);
    chk("R3 idle samples ignored", v, 32'h2000);
    pop_one(); release_one();
    pop_one(); release_one();
    chk("R8 all released", busy, 1'b0);
  endtask

  task automatic t_reject();
    capture(32'h3000, 1'b0, 3);
    chk("R10 rejected count", rej_count, 32'(exp_rej));
    pop_one();
    chk("R10 no event stored for reject", desc_valid, 1'b0);
    release_one();
  endtask

  task automatic t_fill();
    logic [31:0] v;
    for (int e = 0; e < 10; e++) begin
      capture(32'h4000 + 32'(e << 8), 1'b0, 0);
      chk("R7 busy at occupancy", busy, (e == 9) ? 1'b1 : 1'b0);
    end
    release_one();
    chk("R8 release without pop ignored", busy, 1'b1);
    trig_in = 1'b1; @(negedge clk); trig_in = 1'b0;
    exp_rej++;
    chk("R10 reject when full", rej_count, 32'(exp_rej));
    pop_one(); release_one();
    chk("R7 busy drops after release", busy, 1'b0);
    capture(32'h5000, 1'b0, 0);
    chk("R7 full again", busy, 1'b1);
    read_word(qa[(qtl - 1) % 64], v);
    chk("R2 header after wrap", v, {8'hE7, 24'(exp_trig - 1)});
    read_word((qa[(qtl - 1) % 64] + NSAMP) % DEPTH, v);
    chk("R3 last word after wrap", v, 32'h5000 + 32'(NSAMP - 1));
    for (int e = 0; e < 10; e++) begin pop_one(); release_one(); end
    chk("R8 drained", busy, 1'b0);
  endtask

  task automatic t_same_cycle();
    for (int e = 0; e < 9; e++) capture(32'h6000 + 32'(e << 8), 1'b0, 0);
    pop_one();
    trig_in = 1'b1; evt_release = 1'b1;
    @(negedge clk);
    trig_in = 1'b0; evt_release = 1'b0;
    chk("R11 R4 capture started", busy, 1'b1);
    qa[qtl % 64] = exp_wr; qt[qtl % 64] = exp_trig; qtl++;
    exp_wr = (exp_wr + EVT) % DEPTH; exp_trig++;
    for (int i = 0; i < NSAMP; i++) begin
      smp_valid = 1'b1; smp_data = 32'h7000 + 32'(i);
      @(negedge clk);
    end
    smp_valid = 1'b0;
    chk("R11 nine pending after trigger+release", busy, 1'b0);
    capture(32'h7100, 1'b0, 0);
    chk("R11 tenth event fills", busy, 1'b1);
    for (int e = 0; e < 10; e++) begin pop_one(); release_one(); end
    chk("R11 drained", busy, 1'b0);
  endtask

  task automatic t_legacy();
    unbuf_mode = 1'b1;
    @(negedge clk);
    capture(32'h8000, 1'b0, 0);
    chk("R9 busy after capture", busy, 1'b1);
    trig_in = 1'b1; @(negedge clk); trig_in = 1'b0;
    exp_rej++;
    chk("R9 R10 trigger rejected", rej_count, 32'(exp_rej));
    pop_one();
    chk("R9 busy after pop", busy, 1'b1);
    release_one();
    chk("R9 busy cleared by release", busy, 1'b0);
  endtask

  task automatic t_saturate();
    capture(32'h9000, 1'b0, 0);
    trig_in = 1'b1;
    repeat (65540) @(negedge clk);
    trig_in = 1'b0;
    chk("R10 counter saturates", rej_count, 32'hFFFF);
    pop_one(); release_one();
    chk("R9 idle at end", busy, 1'b0);
    unbuf_mode = 1'b0;
  endtask

  initial begin
    t_reset();
    t_single();
    t_reject();
    t_fill();
    t_same_cycle();
    t_legacy();
    t_saturate();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 190000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule